// File: doc/BRIEF.md
# Staggered Three-Camera Frame Trigger Sequencer

This block drives the frame-trigger inputs of three cameras that share one capture port in time division. A programmable slot timer counts system clock cycles to form one frame slot, nominally 1/200 s (500000 cycles at 100 MHz). A capture cycle has three slots. Camera 0 is triggered at the start of slot 0, camera 1 at the start of slot 1 and camera 2 at the start of slot 2. Exactly one camera fires per slot, so each camera delivers one frame per cycle and the port sees the three frames back to back.

Software starts and stops the schedule with a level enable. In auto mode, cycles follow each other without a gap. In restart mode, the sequencer waits after slot 2 until a restart pulse arrives. This lets the frames of one cycle be moved to storage before the next cycle begins. A slot index output and a one-cycle cycle-complete pulse report progress. Each trigger pulse has a programmable width in clock cycles. The block clips the width so that every pulse ends before its slot does.

Top module: `cam_trig_seq`

## Requirements
- R1: While reset is asserted, and afterwards while enable stays low, all triggers are low, the slot index reads 0 and the cycle-complete pulse is low.
- R2: When enable is sampled high in the idle state, the trigger of camera 0 goes high after the second rising clock edge, and the cycle starts in slot 0.
- R3: Within one cycle, the trigger of camera 1 rises exactly L clock cycles after that of camera 0, and the trigger of camera 2 rises L cycles after that of camera 1. L is the effective slot length.
- R4: At most one trigger is high at any time. Each pulse starts at its slot's first cycle and lasts min(P, L-1) cycles, where P is the programmed width. P = 0 gives no pulses.
- R5: The effective slot length L equals the programmed slot length. Programmed values 0 and 1 behave as 2.
- R6: In auto mode (auto_i = 1), a new cycle starts right after slot 2. The trigger of camera 0 then rises 3·L cycles after its previous rise.
- R7: In restart mode (auto_i = 0), after slot 2 the block waits with all triggers low and the slot index reading 2. A restart pulse starts a new cycle, and camera 0 goes high after the second edge. A restart pulse during a running cycle has no effect.
- R8: If enable goes low during a running cycle, the current slot runs to its end. After that, the triggers stay low and the slot index reads 0. If enable goes low while the block waits for restart, it returns to idle at once.
- R9: The slot index output is binary 0, 1 or 2, never 3. It names the slot of the trigger value shown in the same cycle.
- R10: The cycle-complete output is high for exactly one cycle per cycle run, in the last cycle of slot 2 as shown at the outputs (the slot index reads 2). This also happens when the block stops at that boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| enable_i | input | 1 | Level run control; low stops the schedule at the next slot boundary |
| auto_i | input | 1 | 1: cycles repeat continuously; 0: wait for restart after slot 2 |
| restart_i | input | 1 | One-cycle pulse that starts the next cycle in restart mode |
| slot_len_i | input | CNT_W | Slot length in clock cycles (values below 2 act as 2) |
| pulse_len_i | input | PW_W | Trigger pulse width in clock cycles |
| trig_o | output | NUM_CAM | Frame trigger per camera; bit k belongs to camera k |
| slot_idx_o | output | SLOT_W | Slot index of the current trigger output, binary |
| cycle_done_o | output | 1 | One-cycle pulse in the last cycle of slot 2 |

## Verification
A wrong slot counter shows up as a trigger rise that comes too early or too late, within one slot length. The bench measures the spacing between rising edges and compares every output cycle with its own timing model. A wrong slot index or state fires the wrong trigger bit, or a pulse in the waiting state, in the same cycle it goes wrong. A lost or doubled transition shows up as a missing or extra cycle-complete pulse by the end of the cycle in question.

// File: rtl/cam_trig_pkg.sv
package cam_trig_pkg;

  // Sequencer state: idle, running a cycle, or waiting for restart.
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_RUN  = 2'd1,
    SQ_HOLD = 2'd2
  } seq_state_e;

endpackage

// File: rtl/cam_trig_rst_sync.sv
module cam_trig_rst_sync (
  input  logic clk,
  input  logic rst_n_a,
  output logic rst_n_s
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_a) begin
    if (!rst_n_a) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_s = sync_q[1];

endmodule

// File: rtl/cam_trig_slot_timer.sv
module cam_trig_slot_timer #(
  parameter int CNT_W = 32,
  parameter int PW_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [CNT_W-1:0] slot_len_i,
  input  logic [PW_W-1:0]  pulse_len_i,
  output logic             slot_end_o,
  output logic             fire_win_o
);

  localparam logic [CNT_W-1:0] MIN_LEN = CNT_W'(2);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] len_eff, last_cnt, pw_ext, hi_len;
  logic             cnt_en;

  // Effective slot length and clipped pulse window.
  always_comb begin
    len_eff  = (slot_len_i < MIN_LEN) ? MIN_LEN : slot_len_i;
    last_cnt = len_eff - CNT_W'(1);
    pw_ext   = CNT_W'(pulse_len_i);
    hi_len   = (pw_ext < last_cnt) ? pw_ext : last_cnt;
  end

  assign slot_end_o = run_i && (cnt_q >= last_cnt);
  assign fire_win_o = run_i && (cnt_q < hi_len);

  // Next count: cleared outside a run and at each slot end.
  always_comb begin
    if (!run_i || slot_end_o) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
    cnt_en = run_i || (cnt_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/cam_trig_seq_fsm.sv
module cam_trig_seq_fsm
  import cam_trig_pkg::*;
#(
  parameter int NUM_CAM = 3,
  parameter int SLOT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable_i,
  input  logic              auto_i,
  input  logic              restart_i,
  input  logic              slot_end_i,
  output seq_state_e        state_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              run_o,
  output logic              cycle_end_o
);

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_CAM - 1);

  seq_state_e        st_q, st_d;
  logic [SLOT_W-1:0] slot_q, slot_d;

  always_comb begin
    st_d        = st_q;
    slot_d      = slot_q;
    cycle_end_o = 1'b0;
    case (st_q)
      SQ_IDLE: begin
        slot_d = '0;
        if (enable_i) begin
          st_d = SQ_RUN;
        end
      end
      SQ_RUN: begin
        if (slot_end_i) begin
          if (slot_q == LAST_SLOT) begin
            cycle_end_o = 1'b1;
            if (!enable_i) begin
              st_d   = SQ_IDLE;
              slot_d = '0;
            end else if (auto_i) begin
              slot_d = '0;
            end else begin
              st_d = SQ_HOLD;
            end
          end else if (!enable_i) begin
            st_d   = SQ_IDLE;
            slot_d = '0;
          end else begin
            slot_d = slot_q + SLOT_W'(1);
          end
        end
      end
      SQ_HOLD: begin
        if (!enable_i) begin
          st_d   = SQ_IDLE;
          slot_d = '0;
        end else if (restart_i) begin
          st_d   = SQ_RUN;
          slot_d = '0;
        end
      end
      default: begin
        st_d   = SQ_IDLE;
        slot_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      slot_q <= '0;
    end else begin
      st_q   <= st_d;
      slot_q <= slot_d;
    end
  end

  assign state_o = st_q;
  assign slot_o  = slot_q;
  assign run_o   = (st_q == SQ_RUN);

endmodule

// File: rtl/cam_trig_out.sv
module cam_trig_out #(
  parameter int NUM_CAM = 3,
  parameter int SLOT_W  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fire_win_i,
  input  logic [SLOT_W-1:0]  slot_i,
  input  logic               cycle_end_i,
  output logic [NUM_CAM-1:0] trig_o,
  output logic [SLOT_W-1:0]  slot_o,
  output logic               done_o
);

  logic [NUM_CAM-1:0] trig_q;
  logic [SLOT_W-1:0]  slot_q;
  logic               done_q;

  // One registered trigger per camera, selected by slot index.
  for (genvar g = 0; g < NUM_CAM; g++) begin : g_cam
    logic fire_d;
    assign fire_d = fire_win_i && (slot_i == SLOT_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        trig_q[g] <= 1'b0;
      end else begin
        trig_q[g] <= fire_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      done_q <= 1'b0;
    end else begin
      slot_q <= slot_i;
      done_q <= cycle_end_i;
    end
  end

  assign trig_o = trig_q;
  assign slot_o = slot_q;
  assign done_o = done_q;

endmodule

// File: rtl/cam_trig_seq.sv
module cam_trig_seq
  import cam_trig_pkg::*;
#(
  parameter int NUM_CAM = 3,
  parameter int CNT_W   = 32,
  parameter int PW_W    = 16,
  localparam int SLOT_W = (NUM_CAM > 1) ? $clog2(NUM_CAM) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable_i,
  input  logic               auto_i,
  input  logic               restart_i,
  input  logic [CNT_W-1:0]   slot_len_i,
  input  logic [PW_W-1:0]    pulse_len_i,
  output logic [NUM_CAM-1:0] trig_o,
  output logic [SLOT_W-1:0]  slot_idx_o,
  output logic               cycle_done_o
);

  logic              rst_n_s;
  logic              run;
  logic              slot_end;
  logic              fire_win;
  logic              cycle_end;
  logic [SLOT_W-1:0] seq_slot;
  seq_state_e        seq_state;

  cam_trig_rst_sync u_rst (
    .clk     (clk),
    .rst_n_a (rst_n),
    .rst_n_s (rst_n_s)
  );

  cam_trig_slot_timer #(
    .CNT_W (CNT_W),
    .PW_W  (PW_W)
  ) u_timer (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .run_i       (run),
    .slot_len_i  (slot_len_i),
    .pulse_len_i (pulse_len_i),
    .slot_end_o  (slot_end),
    .fire_win_o  (fire_win)
  );

  cam_trig_seq_fsm #(
    .NUM_CAM (NUM_CAM),
    .SLOT_W  (SLOT_W)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .enable_i    (enable_i),
    .auto_i      (auto_i),
    .restart_i   (restart_i),
    .slot_end_i  (slot_end),
    .state_o     (seq_state),
    .slot_o      (seq_slot),
    .run_o       (run),
    .cycle_end_o (cycle_end)
  );

  cam_trig_out #(
    .NUM_CAM (NUM_CAM),
    .SLOT_W  (SLOT_W)
  ) u_out (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .fire_win_i  (fire_win),
    .slot_i      (seq_slot),
    .cycle_end_i (cycle_end),
    .trig_o      (trig_o),
    .slot_o      (slot_idx_o),
    .done_o      (cycle_done_o)
  );

endmodule

// File: rtl/cam_trig_seq_chk.sv
module cam_trig_seq_chk
  import cam_trig_pkg::*;
#(
  parameter int NUM_CAM = 3,
  parameter int SLOT_W  = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_CAM-1:0] trig,
  input logic [SLOT_W-1:0]  slot_idx,
  input logic               done,
  input logic [1:0]         state
);

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_CAM - 1);

  // R4
  trig_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(trig));

  // R9
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(slot_idx) < NUM_CAM);

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  done_last_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (slot_idx == LAST_SLOT));

  // R7
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_HOLD) |=> (trig == '0));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_IDLE) |=> (trig == '0));

endmodule

bind cam_trig_seq cam_trig_seq_chk #(
  .NUM_CAM (NUM_CAM),
  .SLOT_W  (SLOT_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n_s),
  .trig     (trig_o),
  .slot_idx (slot_idx_o),
  .done     (cycle_done_o),
  .state    (seq_state)
);

// File: tb/test_cam_trig_seq.sv
`timescale 1ns/1ps
module test_cam_trig_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        auto_m = 1'b1;
  logic        restart = 1'b0;
  logic [31:0] slot_len = 32'd4;
  logic [15:0] pulse_len = 16'd2;
  logic [2:0]  trig;
  logic [1:0]  slot_idx;
  logic        done;

  cam_trig_seq i_cam_trig_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable_i     (enable),
    .auto_i       (auto_m),
    .restart_i    (restart),
    .slot_len_i   (slot_len),
    .pulse_len_i  (pulse_len),
    .trig_o       (trig),
    .slot_idx_o   (slot_idx),
    .cycle_done_o (done)
  );

  always #2 clk = ~clk;

  int    n_chk = 0, n_bad = 0, cyc = 0, done_cnt = 0;
  string cur_req = "R1";
  bit    cmp_on = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int eff_len(input int l);
    return (l < 2) ? 2 : l;
  endfunction

  function automatic int eff_w(input int p, input int l);
    return (p < eff_len(l) - 1) ? p : eff_len(l) - 1;
  endfunction

  // Timing model from the requirements (state 0 idle, 1 run, 2 wait).
  int m_st, m_slot, m_cnt, e_trig, e_slot, e_done, m_L, m_W;
  bit m_end;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_slot = 0; m_cnt = 0; e_trig = 0; e_slot = 0; e_done = 0;
    end else begin
      m_L    = eff_len(int'(slot_len));
      m_W    = eff_w(int'(pulse_len), int'(slot_len));
      e_trig = (m_st == 1 && m_cnt < m_W) ? (1 << m_slot) : 0;
      m_end  = (m_st == 1) && (m_cnt >= m_L - 1);
      e_slot = m_slot;
      e_done = (m_end && m_slot == 2) ? 1 : 0;
      case (m_st)
        0: begin
          m_slot = 0; m_cnt = 0;
          if (enable) m_st = 1;
        end
        1: begin
          if (m_end) begin
            m_cnt = 0;
            if (m_slot == 2) begin
              if (!enable) begin m_st = 0; m_slot = 0; end
              else if (auto_m) m_slot = 0;
              else m_st = 2;
            end else if (!enable) begin
              m_st = 0; m_slot = 0;
            end else begin
              m_slot = m_slot + 1;
            end
          end else begin
            m_cnt = m_cnt + 1;
          end
        end
        default: begin
          m_cnt = 0;
          if (!enable) begin m_st = 0; m_slot = 0; end
          else if (restart) begin m_st = 1; m_slot = 0; end
        end
      endcase
    end
  end

  // Output compare plus rise and width monitor.
  int rise_t[3], last_w[3], hw[3];
  int prev_rise0 = 0;
  logic [2:0] prev_t = 3'b000;
  always @(negedge clk) begin
    cyc++;
    if (cmp_on) begin
      chk(int'(trig) == e_trig, cur_req, "trig", int'(trig), e_trig);
      chk(int'(slot_idx) == e_slot, "R9", "slot_idx", int'(slot_idx), e_slot);
      chk(int'(done) == e_done, "R10", "cycle_done", int'(done), e_done);
    end
    for (int i = 0; i < 3; i++) begin
      if (trig[i] && !prev_t[i]) begin
        if (i == 0) prev_rise0 = rise_t[0];
        rise_t[i] = cyc;
        hw[i] = 0;
      end
      if (trig[i]) hw[i]++;
      if (!trig[i] && prev_t[i]) last_w[i] = hw[i];
    end
    prev_t = trig;
    if (done) done_cnt++;
  end

  task automatic wait_done(input int n, input string req);
    int target = done_cnt + n;
    int guard = 0;
    while (done_cnt < target && guard < 5000) begin
      @(posedge clk);
      guard++;
    end
    chk(done_cnt >= target, req, "cycle_done count", done_cnt, target);
  endtask

  task automatic go_idle(input int wait_cyc);
    @(negedge clk);
    enable = 1'b0; restart = 1'b0;
    repeat (wait_cyc) @(negedge clk);
  endtask

  // Auto-mode measurement of slot spacing, cycle spacing and widths.
  task automatic measure(input int l, input int p, input string req);
    int el = eff_len(l);
    int ew = eff_w(p, l);
    cur_req = req;
    @(negedge clk);
    slot_len = 32'(l); pulse_len = 16'(p); auto_m = 1'b1; enable = 1'b1;
    wait_done(2, req);
    chk(rise_t[1] - rise_t[0] == el, "R3", "cam1-cam0 gap", rise_t[1] - rise_t[0], el);
    chk(rise_t[2] - rise_t[1] == el, "R3", "cam2-cam1 gap", rise_t[2] - rise_t[1], el);
    chk(rise_t[0] - prev_rise0 == 3 * el, "R6", "cycle spacing",
        rise_t[0] - prev_rise0, 3 * el);
    for (int i = 0; i < 3; i++) begin
      chk(last_w[i] == ew, "R4", "pulse width", last_w[i], ew);
    end
    go_idle(el + 4);
  endtask

  initial begin
    int run_len;
    void'($urandom(32'd7013));
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(trig == 3'b000 && slot_idx == 2'd0 && done == 1'b0, "R1", "outputs in reset",
        int'({trig, slot_idx, done}), 0);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    repeat (5) @(negedge clk);
    chk(trig == 3'b000 && slot_idx == 2'd0, "R1", "outputs after reset",
        int'({trig, slot_idx}), 0);

    // R2: start latency from idle
    cur_req = "R2";
    slot_len = 32'd6; pulse_len = 16'd2; auto_m = 1'b1;
    enable = 1'b1;
    @(negedge clk);
    chk(trig[0] == 1'b0, "R2", "trig0 one edge after enable", int'(trig[0]), 0);
    @(negedge clk);
    chk(trig[0] == 1'b1, "R2", "trig0 two edges after enable", int'(trig[0]), 1);
    go_idle(10);

    // R3, R4, R6 with plain lengths; R5 with lengths 0 and 1
    measure(5, 2, "R3");
    measure(8, 20, "R4");
    measure(3, 1, "R6");
    measure(0, 5, "R5");
    measure(1, 3, "R5");

    // R7: restart mode waits, restart while running is ignored
    cur_req = "R7";
    @(negedge clk);
    slot_len = 32'd5; pulse_len = 16'd2; auto_m = 1'b0; enable = 1'b1;
    repeat (7) @(negedge clk);
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    wait_done(1, "R7");
    repeat (10) @(negedge clk);
    chk(trig == 3'b000, "R7", "trig while waiting", int'(trig), 0);
    chk(slot_idx == 2'd2, "R7", "slot while waiting", int'(slot_idx), 2);
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    chk(trig[0] == 1'b0, "R7", "trig0 one edge after restart", int'(trig[0]), 0);
    @(negedge clk);
    chk(trig[0] == 1'b1, "R7", "trig0 two edges after restart", int'(trig[0]), 1);
    wait_done(1, "R7");
    repeat (4) @(negedge clk);
    // R8: enable low while waiting returns to idle
    enable = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(slot_idx == 2'd0, "R8", "slot after stop in wait", int'(slot_idx), 0);
    go_idle(4);

    // R8: enable low mid-slot completes the slot, then idle
    cur_req = "R8";
    @(negedge clk);
    slot_len = 32'd6; pulse_len = 16'd3; auto_m = 1'b1; enable = 1'b1;
    for (int g = 0; g < 100 && slot_idx != 2'd1; g++) @(negedge clk);
    @(negedge clk);
    enable = 1'b0;
    repeat (10) @(negedge clk);
    chk(trig == 3'b000 && slot_idx == 2'd0, "R8", "outputs after stop",
        int'({trig, slot_idx}), 0);
    chk(rise_t[2] < rise_t[1], "R8", "cam2 fired after stop", rise_t[2], rise_t[1]);

    // Random mix of lengths, modes, restarts and enable toggles
    for (int it = 0; it < 40; it++) begin
      cur_req = (it % 2 == 0) ? "R6" : "R7";
      @(negedge clk);
      slot_len = 32'($urandom_range(12, 0));
      pulse_len = 16'($urandom_range(14, 0));
      auto_m = 1'($urandom_range(1, 0));
      enable = 1'b1;
      run_len = $urandom_range(90, 20);
      for (int k = 0; k < run_len; k++) begin
        @(negedge clk);
        restart = ($urandom_range(7, 0) == 0);
        if ($urandom_range(40, 0) == 0) enable = ~enable;
      end
      go_idle(16);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R1: run not finished, actual cycles %0d expected fewer than %0d",
             cyc, 150000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule